// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block is the bit-level timing engine that sits on the target side of a single-wire debug link. The link uses one pseudo-open-drain pin. The host opens every bit time by pulling the line low. The target then times the rest of the bit with its own bus clock. The engine brings the raw pin into the clock domain and decides when a bit time begins. For a bit coming from the host, it samples the line at a fixed point. For a bit going to the host, it drives the line at fixed points.

A byte-level framer above the engine has two jobs. It collects received bits from a one-cycle strobe. Before the host starts a bit that the target must answer, it arms that bit with a transmit request. A bit that is not armed is treated as a receive bit. When the target sends a 0, it holds the line low for a fixed interval. When it sends a 1, it leaves the line to the host. In both cases it ends with a one-cycle active-high pulse, so the rising edge does not depend on a slow pull-up.

Top module: `dbg_bit_engine`

## Requirements
- R1: After synchronous reset, `pin_oe`, `rx_valid` and `tx_done` are 0.
- R2: A bit time starts only when the synchronized line has been high and is then low for at least two consecutive clock samples. With the raw pin low from just before rising edge 1, the engine takes the start on rising edge 4, called E0. A low pulse that covers only one rising edge starts nothing.
- R3: On a receive bit, `rx_valid` is high for exactly one cycle. It goes high on E0+10, and `rx_bit` then carries the synchronized line level. That level is the raw pin as sampled at E0+8.
- R4: During a receive bit, `pin_oe` stays 0.
- R5: A `tx_req` pulse while idle arms the next bit as a transmit bit and stores `tx_bit`. Starting that bit clears the arming, so the bit after it is a receive bit again. A transmit bit never raises `rx_valid`.
- R6: When sending 1, `pin_oe` stays 0 until E0+7. From E0+7 to E0+8, `pin_oe`=1 and `pin_out`=1. At E0+8 the line is released.
- R7: When sending 0, `pin_oe`=1 and `pin_out`=0 from E0 up to E0+13, which is 13 cycles. From E0+13 to E0+14, `pin_out`=1. At E0+14 the line is released.
- R8: `tx_done` is high for exactly one cycle, in the cycle after the line is released: from E0+8 for a 1, and from E0+14 for a 0.
- R9: A bit-start pattern that appears while a bit time is in progress is ignored. It does not start a new bit once the engine is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Debug pin level from the pad, asynchronous |
| pin_out | output | 1 | Level driven onto the pin when enabled |
| pin_oe | output | 1 | Output enable for the pin driver |
| rx_valid | output | 1 | One-cycle strobe: a received bit is ready |
| rx_bit | output | 1 | Received bit value, valid with `rx_valid` |
| tx_req | input | 1 | Pulse while idle: next bit is a transmit bit |
| tx_bit | input | 1 | Value to send, taken with `tx_req` |
| tx_done | output | 1 | One-cycle strobe: transmitted bit finished |

## Verification
Every result is timed from the first rising edge after the host pulls the pin low. The start falls on the fourth rising edge because two synchronizer flops and one history flop sit in front of it. After that start, the receive strobe is due 10 edges later. A driven-high pulse is due 7 edges later for a 1 and 13 edges later for a 0, and the release and done strobe follow one edge after that. Each scenario task advances the clock one falling edge at a time from the moment it drives the pin. It compares the outputs at the falling edge just after the edge where a change is due, and also at the edge just before, so a result that is one cycle early or late is reported. The cases where input must be ignored are checked by counting receive strobes and enable cycles over a long window after the stimulus.

// File: rtl/dbg_bit_pkg.sv
package dbg_bit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX0  = 2'd2,
    ST_TX1  = 2'd3
  } bit_state_t;
endpackage

// File: rtl/dbg_start_detect.sv
module dbg_start_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic line_sync,
  output logic start
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [MIN_LOW-1:0]     hist_q;
  logic [MIN_LOW:0]       window;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
      hist_q <= {hist_q[MIN_LOW-2:0], line_sync};
    end
  end

  always_comb begin
    line_sync = sync_q[SYNC_STAGES-1];
    window    = {hist_q, line_sync};
    start     = window[MIN_LOW] & ~(|window[MIN_LOW-1:0]);
  end

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
endmodule

// File: rtl/dbg_bit_sequencer.sv
module dbg_bit_sequencer
  import dbg_bit_pkg::*;
#(
  parameter int SAMPLE_CYC   = 10,
  parameter int HI_PULSE_CYC = 7,
  parameter int LOW_CYC      = 13,
  parameter int CNT_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             line_sync,
  input  logic             tx_req,
  input  logic             tx_bit,
  output bit_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             launch_low,
  output logic             rx_valid,
  output logic             rx_bit,
  output logic             tx_done
);
  localparam logic [CNT_W-1:0] K_SAMPLE  = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] K_TX1_END = CNT_W'(HI_PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] K_TX0_END = CNT_W'(LOW_CYC + 1);

  logic             armed;
  logic             arm_bit;
  logic             launch;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    launch     = start && (state == ST_IDLE);
    launch_low = launch && armed && !arm_bit;
    nxt        = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      armed    <= 1'b0;
      arm_bit  <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            cnt   <= '0;
            armed <= 1'b0;
            state <= armed ? (arm_bit ? ST_TX1 : ST_TX0) : ST_RX;
          end else if (tx_req) begin
            armed   <= 1'b1;
            arm_bit <= tx_bit;
          end
        end
        ST_RX: begin
          cnt <= nxt;
          if (nxt == K_SAMPLE) begin
            state    <= ST_IDLE;
            rx_valid <= 1'b1;
            rx_bit   <= line_sync;
          end
        end
        ST_TX0: begin
          cnt <= nxt;
          if (nxt == K_TX0_END) begin
            state   <= ST_IDLE;
            tx_done <= 1'b1;
          end
        end
        ST_TX1: begin
          cnt <= nxt;
          if (nxt == K_TX1_END) begin
            state   <= ST_IDLE;
            tx_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R3
  rx_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(state) == ST_RX);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state == ST_IDLE) || (state == $past(state)));
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= K_TX0_END);
endmodule

// File: rtl/dbg_pin_driver.sv
module dbg_pin_driver
  import dbg_bit_pkg::*;
#(
  parameter int HI_PULSE_CYC = 7,
  parameter int LOW_CYC      = 13,
  parameter int CNT_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  bit_state_t       state,
  input  logic [CNT_W-1:0] cnt,
  input  logic             launch_low,
  output logic             pin_oe,
  output logic             pin_out
);
  localparam logic [CNT_W-1:0] K_HI  = CNT_W'(HI_PULSE_CYC);
  localparam logic [CNT_W-1:0] K_LOW = CNT_W'(LOW_CYC);

  logic [CNT_W-1:0] nxt;
  logic             oe_d;
  logic             out_d;

  always_comb begin
    nxt   = cnt + 1'b1;
    oe_d  = 1'b0;
    out_d = 1'b0;
    if (launch_low) begin
      oe_d = 1'b1;
    end else begin
      case (state)
        ST_TX0: begin
          if (nxt < K_LOW) begin
            oe_d = 1'b1;
          end else if (nxt == K_LOW) begin
            oe_d  = 1'b1;
            out_d = 1'b1;
          end
        end
        ST_TX1: begin
          if (nxt == K_HI) begin
            oe_d  = 1'b1;
            out_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      pin_oe  <= oe_d;
      pin_out <= out_d;
    end
  end

  // R6
  spd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_oe) |-> $past(pin_out));
  // R7
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX0 && pin_oe && !pin_out) |=> pin_oe);
endmodule

// File: rtl/dbg_bit_engine.sv
module dbg_bit_engine
  import dbg_bit_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 2,
  parameter int SAMPLE_CYC   = 10,
  parameter int HI_PULSE_CYC = 7,
  parameter int LOW_CYC      = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic pin_out,
  output logic pin_oe,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_req,
  input  logic tx_bit,
  output logic tx_done
);
  localparam int CNT_W = $clog2(LOW_CYC + 2);

  logic             line_sync;
  logic             start;
  logic             launch_low;
  bit_state_t       state;
  logic [CNT_W-1:0] cnt;

  dbg_start_detect #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_LOW)
  ) i_detect (
    .clk      (clk),
    .rst      (rst),
    .pin_raw  (pin_raw),
    .line_sync(line_sync),
    .start    (start)
  );

  dbg_bit_sequencer #(
    .SAMPLE_CYC  (SAMPLE_CYC),
    .HI_PULSE_CYC(HI_PULSE_CYC),
    .LOW_CYC     (LOW_CYC),
    .CNT_W       (CNT_W)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .line_sync (line_sync),
    .tx_req    (tx_req),
    .tx_bit    (tx_bit),
    .state     (state),
    .cnt       (cnt),
    .launch_low(launch_low),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .tx_done   (tx_done)
  );

  dbg_pin_driver #(
    .HI_PULSE_CYC(HI_PULSE_CYC),
    .LOW_CYC     (LOW_CYC),
    .CNT_W       (CNT_W)
  ) i_drv (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .cnt       (cnt),
    .launch_low(launch_low),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
  );

  // R4
  rx_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX) |-> !pin_oe);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !pin_oe);
endmodule

// File: tb/test_dbg_bit_engine.sv
`timescale 1ns/1ps
module test_dbg_bit_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_low = 1'b0;
  logic pin_raw;
  logic pin_out, pin_oe, rx_valid, rx_bit, tx_done;
  logic tx_req = 1'b0;
  logic tx_bit = 1'b0;
  int checks = 0;
  int failures = 0;
  int rel = 0;
  int rx_pulses = 0;
  int oe_cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign pin_raw = host_low ? 1'b0 : (pin_oe ? pin_out : 1'b1);

  dbg_bit_engine i_dbg_bit_engine (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .pin_out(pin_out),
    .pin_oe(pin_oe), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tx_req(tx_req), .tx_bit(tx_bit), .tx_done(tx_done)
  );

  always @(negedge clk) begin
    if (rx_valid) rx_pulses++;
    if (pin_oe) oe_cycles++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go(input int k);
    while (rel < k) begin
      @(negedge clk);
      rel++;
    end
  endtask

  task automatic host_start();
    @(negedge clk);
    host_low = 1'b1;
    rel = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pin_oe == 1'b0, "R1", "pin_oe", pin_oe, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(tx_done == 1'b0, "R1", "tx_done", tx_done, 0);
  endtask

  task automatic t_rx(input bit val, input string tag);
    int p0, o0;
    p0 = rx_pulses;
    o0 = oe_cycles;
    host_start();
    go(val ? 3 : 13);
    host_low = 1'b0;
    go(13);
    chk(rx_valid == 1'b0, "R3", {tag, " early strobe"}, rx_valid, 0);
    go(14);
    chk(rx_valid == 1'b1, "R3", {tag, " strobe at E0+10"}, rx_valid, 1);
    chk(rx_bit == val, "R3", {tag, " rx_bit"}, rx_bit, val);
    go(15);
    chk(rx_valid == 1'b0, "R3", {tag, " strobe width"}, rx_valid, 0);
    go(24);
    chk(oe_cycles == o0, "R4", {tag, " no drive"}, oe_cycles - o0, 0);
    chk(rx_pulses == p0 + 1, "R3", {tag, " strobe count"}, rx_pulses - p0, 1);
  endtask

  task automatic arm(input bit val);
    @(negedge clk);
    tx_req = 1'b1;
    tx_bit = val;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic t_tx0();
    int p0;
    p0 = rx_pulses;
    arm(1'b0);
    host_start();
    go(4);
    host_low = 1'b0;
    chk(pin_oe && !pin_out, "R7", "low at E0", {pin_oe, pin_out}, 2);
    go(16);
    chk(pin_oe && !pin_out, "R7", "low at E0+12", {pin_oe, pin_out}, 2);
    chk(tx_done == 1'b0, "R8", "tx0 early done", tx_done, 0);
    go(17);
    chk(pin_oe && pin_out, "R7", "pulse at E0+13", {pin_oe, pin_out}, 3);
    go(18);
    chk(pin_oe == 1'b0, "R7", "release at E0+14", pin_oe, 0);
    chk(tx_done == 1'b1, "R8", "tx0 done", tx_done, 1);
    go(19);
    chk(tx_done == 1'b0, "R8", "tx0 done width", tx_done, 0);
    go(26);
    chk(rx_pulses == p0, "R5", "tx0 no rx strobe", rx_pulses - p0, 0);
  endtask

  task automatic t_tx1();
    int p0, o0;
    p0 = rx_pulses;
    arm(1'b1);
    o0 = oe_cycles;
    host_start();
    go(3);
    host_low = 1'b0;
    go(10);
    chk(pin_oe == 1'b0, "R6", "no drive before E0+7", pin_oe, 0);
    go(11);
    chk(pin_oe && pin_out, "R6", "pulse at E0+7", {pin_oe, pin_out}, 3);
    go(12);
    chk(pin_oe == 1'b0, "R6", "release at E0+8", pin_oe, 0);
    chk(tx_done == 1'b1, "R8", "tx1 done", tx_done, 1);
    go(13);
    chk(tx_done == 1'b0, "R8", "tx1 done width", tx_done, 0);
    go(22);
    chk(oe_cycles == o0 + 1, "R6", "one drive cycle", oe_cycles - o0, 1);
    chk(rx_pulses == p0, "R5", "tx1 no rx strobe", rx_pulses - p0, 0);
  endtask

  task automatic t_glitch();
    int p0;
    p0 = rx_pulses;
    host_start();
    go(1);
    host_low = 1'b0;
    go(30);
    chk(rx_pulses == p0, "R2", "one-cycle low ignored", rx_pulses - p0, 0);
    chk(pin_oe == 1'b0, "R2", "no drive after glitch", pin_oe, 0);
  endtask

  task automatic t_busy();
    int p0;
    p0 = rx_pulses;
    host_start();
    go(3);
    host_low = 1'b0;
    go(6);
    host_low = 1'b1;
    go(9);
    host_low = 1'b0;
    go(14);
    chk(rx_valid == 1'b1, "R9", "first bit strobe", rx_valid, 1);
    chk(rx_bit == 1'b1, "R9", "first bit value", rx_bit, 1);
    go(45);
    chk(rx_pulses == p0 + 1, "R9", "edge while busy ignored", rx_pulses - p0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rx(1'b1, "rx1");
    t_rx(1'b0, "rx0");
    t_tx0();
    t_tx1();
    t_rx(1'b1, "R5 after tx");
    t_glitch();
    t_busy();
    t_rx(1'b0, "rx0 final");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule